// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This unit is a 32-bit arithmetic slice for signal-processing instructions. Its result path is combinational. It covers signed saturating add and subtract, a wrapping signed add that still reports overflow, a saturating doubling, unsigned saturating add and subtract, and clamping of a value to a selectable bit width. The clamp comes in signed and unsigned forms, and each form has a variant that works on both 16-bit halves at once.

Every operation that has to clamp or overflow raises a per-cycle hit. The hit feeds one registered sticky flag. The flag stays set until software-visible logic outside the unit asserts the clear input. The operation code is applied together with the operands, and the result is read in the same cycle. The sticky flag reflects the operation one clock edge later.

Top module: `satu_top`

## Requirements
- R1: Operation code 0 is the signed saturating add. When A and B share a sign and the sum's sign differs from A's, the result is 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative, and a hit is raised. Otherwise the result is the wrapped sum.
- R2: Operation code 1 always returns the wrapped 32-bit sum. It raises a hit under the same overflow rule as R1.
- R3: Operation code 2 is the signed saturating A minus B. Overflow occurs when A and B differ in sign and the difference's sign differs from A's. The saturation values are the same as in R1.
- R4: Operation code 3 doubles A. When A as a signed value is at least 0x40000000, the result is 0x7FFFFFFF with a hit. When A is at most 0xC0000000 as a signed value (0xC0000000 included), the result is 0x80000000 with a hit. Otherwise the result is A shifted left by one.
- R5: Operation code 4 is the unsigned add. The result is 0xFFFFFFFF with a hit when the sum carries out of 32 bits.
- R6: Operation code 5 is the unsigned A minus B. The result is 0 with a hit when B is greater than A.
- R7: Operation code 6 clamps signed A to the range from -(2^n) to 2^n-1, where n is the 5-bit width input. A clamp raises a hit.
- R8: Operation code 7 clamps A, taken as signed, to the range 0 to 2^n-1. A clamp raises a hit.
- R9: Operation codes 8 (signed) and 9 (unsigned) apply the R7 and R8 clamps separately to the sign-extended low half (bits 15:0) and high half (bits 31:16). Each lane's low 16 bits go back into its own half. The hit is the OR of the two lanes.
- R10: The sticky flag sets on the clock edge after any hit and holds when there is no hit. With the clear input high, the next value of the flag equals that cycle's hit, so a hit in the same cycle as the clear wins.
- R11: While reset is asserted (active low) the sticky flag is 0.
- R12: Operation codes 10 to 15 give a zero result and raise no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opSel | input | 4 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| satWidth | input | 5 | Clamp width n for codes 6 to 9 |
| stickyClr | input | 1 | Clears the sticky flag on the next edge |
| result | output | 32 | Combinational result |
| stickyFlag | output | 1 | Registered sticky saturation flag |

## Verification
Two situations are the hardest to reach from the ports. The first is a clear that lands in the same cycle as a saturating operation. The second is a dual-lane clamp in which only one half saturates, so the OR of the lane hits matters. The stimulus pulses the clear every seventh operation across the full corner sweep, so clears fall on both saturating and non-saturating operations. The corner operand set mixes values whose halves lie on opposite sides of every clamp width from 0 to 31.

// File: rtl/satu_pkg.sv
package satu_pkg;

  localparam logic [3:0] OPC_QADD  = 4'd0;
  localparam logic [3:0] OPC_QADDW = 4'd1;
  localparam logic [3:0] OPC_QSUB  = 4'd2;
  localparam logic [3:0] OPC_QDBL  = 4'd3;
  localparam logic [3:0] OPC_UADD  = 4'd4;
  localparam logic [3:0] OPC_USUB  = 4'd5;
  localparam logic [3:0] OPC_SCLP  = 4'd6;
  localparam logic [3:0] OPC_UCLP  = 4'd7;
  localparam logic [3:0] OPC_SCLP2 = 4'd8;
  localparam logic [3:0] OPC_UCLP2 = 4'd9;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_SUB, K_DBL, K_UADD, K_USUB, K_CLAMP
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  wrapOnly;
    logic  clampSigned;
    logic  dualLane;
  } strobe_t;

endpackage

// File: rtl/satu_clamp.sv
module satu_clamp #(
  parameter int IN_W   = 32,
  parameter int CALC_W = 33,
  parameter int WID_W  = 5
) (
  input  logic [IN_W-1:0]  val,
  input  logic [WID_W-1:0] width,
  input  logic             isSigned,
  output logic [IN_W-1:0]  res,
  output logic             hit
);
  logic signed [CALC_W-1:0] ext;
  logic signed [CALC_W-1:0] hiLim;
  logic signed [CALC_W-1:0] loLim;
  logic signed [CALC_W-1:0] chosen;

  always_comb begin
    ext   = {{(CALC_W-IN_W){val[IN_W-1]}}, val};
    hiLim = (CALC_W'(1) << width) - CALC_W'(1);
    loLim = ~hiLim;
    chosen = ext;
    hit    = 1'b0;
    if (isSigned) begin
      if (ext > hiLim) begin
        chosen = hiLim;
        hit    = 1'b1;
      end else if (ext < loLim) begin
        chosen = loLim;
        hit    = 1'b1;
      end
    end else begin
      if (ext < 0) begin
        chosen = '0;
        hit    = 1'b1;
      end else if (ext > hiLim) begin
        chosen = hiLim;
        hit    = 1'b1;
      end
    end
    res = chosen[IN_W-1:0];
  end
endmodule

// File: rtl/satu_dp.sv
module satu_dp
  import satu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WID_W  = 5,
  parameter int LANES  = 2
) (
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [WID_W-1:0]  satWidth,
  output logic [DATA_W-1:0] result,
  output logic              satHit
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int MSB    = DATA_W - 1;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sumW, diffW, satOfA;
  logic [DATA_W:0]   uSum;
  logic              addOvf, subOvf, dblHigh, dblLow;

  logic [DATA_W-1:0] fullRes;
  logic              fullHit;
  logic [DATA_W-1:0] laneRes;
  logic [LANES-1:0]  laneHit;

  always_comb begin
    sumW    = opA + opB;
    diffW   = opA - opB;
    uSum    = {1'b0, opA} + {1'b0, opB};
    satOfA  = opA[MSB] ? NEG_MIN : POS_MAX;
    addOvf  = (sumW[MSB] ^ opA[MSB]) & ~(opA[MSB] ^ opB[MSB]);
    subOvf  = (diffW[MSB] ^ opA[MSB]) & (opA[MSB] ^ opB[MSB]);
    dblHigh = ~opA[MSB] & opA[MSB-1];
    dblLow  = opA[MSB] & (~opA[MSB-1] | (opA[MSB-2:0] == '0));
  end

  satu_clamp #(.IN_W(DATA_W), .CALC_W(DATA_W+1), .WID_W(WID_W)) fullClamp_i (
    .val(opA), .width(satWidth), .isSigned(strobe.clampSigned),
    .res(fullRes), .hit(fullHit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    satu_clamp #(.IN_W(LANE_W), .CALC_W(DATA_W+1), .WID_W(WID_W)) laneClamp_i (
      .val(opA[l*LANE_W +: LANE_W]), .width(satWidth),
      .isSigned(strobe.clampSigned),
      .res(laneRes[l*LANE_W +: LANE_W]), .hit(laneHit[l])
    );
  end

  always_comb begin
    result = '0;
    satHit = 1'b0;
    case (strobe.kind)
      K_ADD: begin
        satHit = addOvf;
        result = (addOvf && !strobe.wrapOnly) ? satOfA : sumW;
      end
      K_SUB: begin
        satHit = subOvf;
        result = subOvf ? satOfA : diffW;
      end
      K_DBL: begin
        satHit = dblHigh | dblLow;
        if (dblHigh)     result = POS_MAX;
        else if (dblLow) result = NEG_MIN;
        else             result = {opA[MSB-1:0], 1'b0};
      end
      K_UADD: begin
        satHit = uSum[DATA_W];
        result = uSum[DATA_W] ? '1 : uSum[DATA_W-1:0];
      end
      K_USUB: begin
        satHit = (opB > opA);
        result = (opB > opA) ? '0 : diffW;
      end
      K_CLAMP: begin
        satHit = strobe.dualLane ? |laneHit : fullHit;
        result = strobe.dualLane ? laneRes : fullRes;
      end
      default: begin
        result = '0;
        satHit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/satu_ctrl.sv
module satu_ctrl
  import satu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opSel,
  input  logic       stickyClr,
  input  logic       satHit,
  output strobe_t    strobe,
  output logic       stickyFlag
);
  always_comb begin
    strobe = '{kind: K_NONE, wrapOnly: 1'b0, clampSigned: 1'b0, dualLane: 1'b0};
    case (opSel)
      OPC_QADD:  strobe.kind = K_ADD;
      OPC_QADDW: begin strobe.kind = K_ADD; strobe.wrapOnly = 1'b1; end
      OPC_QSUB:  strobe.kind = K_SUB;
      OPC_QDBL:  strobe.kind = K_DBL;
      OPC_UADD:  strobe.kind = K_UADD;
      OPC_USUB:  strobe.kind = K_USUB;
      OPC_SCLP:  begin strobe.kind = K_CLAMP; strobe.clampSigned = 1'b1; end
      OPC_UCLP:  strobe.kind = K_CLAMP;
      OPC_SCLP2: begin
        strobe.kind = K_CLAMP; strobe.clampSigned = 1'b1; strobe.dualLane = 1'b1;
      end
      OPC_UCLP2: begin strobe.kind = K_CLAMP; strobe.dualLane = 1'b1; end
      default:   strobe.kind = K_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stickyFlag <= 1'b0;
    else if (stickyClr) stickyFlag <= satHit;
    else                stickyFlag <= stickyFlag | satHit;
  end
endmodule

// File: rtl/satu_top.sv
module satu_top
  import satu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WID_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [WID_W-1:0]  satWidth,
  input  logic              stickyClr,
  output logic [DATA_W-1:0] result,
  output logic              stickyFlag
);
  strobe_t strobe;
  logic    satHit;

  satu_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .opSel(opSel), .stickyClr(stickyClr),
    .satHit(satHit), .strobe(strobe), .stickyFlag(stickyFlag)
  );

  satu_dp #(.DATA_W(DATA_W), .WID_W(WID_W), .LANES(2)) dp_i (
    .strobe(strobe), .opA(opA), .opB(opB), .satWidth(satWidth),
    .result(result), .satHit(satHit)
  );
endmodule

// File: rtl/satu_checker.sv
module satu_checker
  import satu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              satHit,
  input logic              stickyClr,
  input logic              stickyFlag
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] DBL_TH = DATA_W'(1) << (DATA_W-2);

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stickyFlag && !stickyClr) |=> stickyFlag);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stickyClr && !satHit) |=> !stickyFlag);

  assert_hit_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    satHit |=> stickyFlag);

  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel >= 4'd10) |-> (result == '0 && !satHit));

  assert_dbl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OPC_QDBL && $signed(opA) >= DBL_TH) |-> (result == POS_MAX && satHit));

  assert_usub_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OPC_USUB && opB > opA) |-> (result == '0));

  assert_uadd_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OPC_UADD) |-> (result >= opA));

  assert_qadd_rail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (opSel == OPC_QADD && satHit) |-> (result == POS_MAX || result == NEG_MIN));
endmodule

bind satu_top satu_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .opSel(opSel), .opA(opA), .opB(opB),
  .result(result), .satHit(satHit), .stickyClr(stickyClr), .stickyFlag(stickyFlag)
);

// File: tb/satu_top_tb_top.sv
module satu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opSel = 4'd15;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  satWidth = '0;
  logic        stickyClr = 1'b0;
  logic [31:0] result;
  logic        stickyFlag;

  int nChecks = 0, nErrors = 0;
  logic expSticky = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  satu_top dut_i (
    .clk(clk), .rst_n(rst_n), .opSel(opSel), .opA(opA), .opB(opB),
    .satWidth(satWidth), .stickyClr(stickyClr), .result(result),
    .stickyFlag(stickyFlag)
  );

  logic [31:0] vals [12] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h4000_0000, 32'hC000_0000,
    32'h3FFF_FFFF, 32'hC000_0001, 32'h0000_7FFF, 32'h8000_8000,
    32'h1234_F678};

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [32:0] refClamp(longint v, int n, bit sgn);
    longint hi = (64'sd1 <<< n) - 1;
    longint lo = -(hi + 1);
    if (sgn) begin
      if (v > hi) return {1'b1, hi[31:0]};
      if (v < lo) return {1'b1, lo[31:0]};
    end else begin
      if (v < 0)  return {1'b1, 32'd0};
      if (v > hi) return {1'b1, hi[31:0]};
    end
    return {1'b0, v[31:0]};
  endfunction

  function automatic logic [32:0] refOp(logic [3:0] op, logic [31:0] a,
                                        logic [31:0] b, logic [4:0] n);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = {32'd0, a};
    longint ub = {32'd0, b};
    longint t;
    logic [32:0] lo, hi;
    case (op)
      4'd0, 4'd1, 4'd2: begin
        t = (op == 4'd2) ? sa - sb : sa + sb;
        if (t > 64'sh7FFF_FFFF)
          return {1'b1, (op == 4'd1) ? t[31:0] : 32'h7FFF_FFFF};
        if (t < -64'sh8000_0000)
          return {1'b1, (op == 4'd1) ? t[31:0] : 32'h8000_0000};
        return {1'b0, t[31:0]};
      end
      4'd3: begin
        if (sa >= 64'sh4000_0000)  return {1'b1, 32'h7FFF_FFFF};
        if (sa <= -64'sh4000_0000) return {1'b1, 32'h8000_0000};
        t = sa * 2;
        return {1'b0, t[31:0]};
      end
      4'd4: begin
        t = ua + ub;
        if (t > 64'hFFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
        return {1'b0, t[31:0]};
      end
      4'd5: begin
        if (ub > ua) return {1'b1, 32'd0};
        t = ua - ub;
        return {1'b0, t[31:0]};
      end
      4'd6, 4'd7: return refClamp(sa, int'(n), op == 4'd6);
      4'd8, 4'd9: begin
        lo = refClamp(longint'($signed(a[15:0])), int'(n), op == 4'd8);
        hi = refClamp(longint'($signed(a[31:16])), int'(n), op == 4'd8);
        return {lo[32] | hi[32], hi[15:0], lo[15:0]};
      end
      default: return 33'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [4:0] n, bit clr);
    logic [32:0] e;
    @(negedge clk);
    opSel = op; opA = a; opB = b; satWidth = n; stickyClr = clr;
    #1;
    e = refOp(op, a, b, n);
    check(reqOf(op), result, e[31:0]);
    @(posedge clk);
    expSticky = clr ? e[32] : (expSticky | e[32]);
    #1;
    check("R10", {31'd0, stickyFlag}, {31'd0, expSticky});
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    int k = 0;
    logic [31:0] lfsr = 32'hACE1_2468;
    repeat (3) @(posedge clk);
    #1;
    check("R11", {31'd0, stickyFlag}, 32'd0);
    check("R12", result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: no hit keeps the flag clear, a hit sets it, it holds, clear drops it
    apply(4'd15, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b0);
    apply(4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b0);
    apply(4'd0, 32'h1, 32'h1, 5'd0, 1'b0);
    apply(4'd15, 32'h0, 32'h0, 5'd0, 1'b0);
    apply(4'd15, 32'h0, 32'h0, 5'd0, 1'b1);
    apply(4'd4, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1);
    apply(4'd15, 32'h0, 32'h0, 5'd0, 1'b0);

    // R1..R6 corner sweep with periodic clears
    for (int op = 0; op < 6; op++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++) begin
          apply(4'(op), vals[i], vals[j], 5'd0, (k % 7) == 0);
          k++;
        end

    // R7, R8, R9 across all widths
    for (int op = 6; op < 10; op++)
      for (int i = 0; i < 12; i++)
        for (int n = 0; n < 32; n++) begin
          apply(4'(op), vals[i], vals[(i + 5) % 12], 5'(n), (k % 7) == 0);
          k++;
        end

    // R12 unused codes
    for (int op = 10; op < 16; op++)
      for (int i = 0; i < 12; i++)
        apply(4'(op), vals[i], vals[11 - i], 5'(i), 1'b0);

    // pseudo-random mix of all codes
    for (int r = 0; r < 2000; r++) begin
      logic [31:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      apply(4'(r % 10), ra, rb, rb[4:0], (r % 11) == 0);
    end

    finishRun();
  end
endmodule